// File: doc/BRIEF.md
# Timer/Counter with Match Outputs, Input Capture and Clearable Event Flags

This block is a free-running timer/counter for a general-purpose peripheral slot. A small register bus sets it up and reads it back. The counter either steps on every clock (timer mode) or steps on chosen edges of one of the external capture inputs (counter mode). Four match channels compare the counter with programmable values. On a hit, a channel can raise an event flag, it raises its DMA request, and it can drive its own output pin high, low, or to the opposite level. Two capture channels each pass their input through a two-stage synchroniser. On a chosen edge, the channel snapshots the counter and raises its own flag.

Software clears flags by writing ones to the flag register. Clearing a match flag also withdraws that channel's DMA request. The interrupt line is the OR of all flags. Bus reads are combinational from the word address. Bus writes take effect at the clock edge on which they are presented.

Register map (word addresses): 0 flags, 1 control, 2 count source, 3 capture edge config, 4 match flag enable, 5 match pins, 6 counter (read only), 8–11 match values 0–3, 12–13 capture values 0–1. Every other address reads zero.

Top module: `tmrCapMatch`

## Requirements
- R1: After reset, the following all read zero: counter, capture values, flags, DMA requests, match pins, control, and every configuration register. The counter is in timer mode after reset.
- R2: In the flag register, match flags 0–3 sit at bits 0–3 and capture flags 0–1 sit at bits 4–5. All higher bits read zero.
- R3: Writing a one to a flag bit clears that flag at the write edge. Writing a zero leaves the flag unchanged.
- R4: If a hardware event and a write-one-to-clear hit the same flag at the same edge, the flag ends up set.
- R5: A match event for channel k happens when the counter steps to the value of match register k. At that same edge, DMA request k rises. Match flag k also rises, but only if bit k of the enable register (address 4) is set.
- R6: Writing a one to flag bit k (k = 0..3) drops DMA request k at that edge, unless a new match on channel k happens at that same edge.
- R7: Each capture input passes through two flip-flops. Its edge select (address 3, bits 2i+1:2i: 0 off, 1 rising, 2 falling, 3 both) picks which edges count. The chosen edge loads the counter value into capture register i and sets capture flag i. This happens at the third clock edge after the input changes. The value stored is the counter as it read just before that edge.
- R8: Count source register (address 2): bits 1:0 give the mode and bit 2 picks the capture input. Mode 0 steps the counter every clock. Modes 1, 2 and 3 step it on rising, falling or both edges of the synchronised input, using the same detection as capture.
- R9: Control register (address 1): bit 0 runs the counter. While bit 0 is clear, the counter holds its value. Bit 1 forces the counter to zero, and no match events occur while it is set.
- R10: Match pin register (address 5): bits 3:0 are the pin levels and can be written. Bits 2k+5:2k+4 give channel k's match action: 0 keep, 1 drive low, 2 drive high, 3 toggle. An action is applied at the match edge, after any write at that same edge.
- R11: The interrupt output is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write when high (with busSel) |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| capIn | input | 2 | Capture / count inputs, asynchronous |
| matchOut | output | 4 | Match output pins |
| dmaReq | output | 4 | Per-match-channel DMA request |
| irq | output | 1 | Interrupt, OR of all flags |

## Verification
Each result has a fixed latency, and the checks are timed to match it:
- A match flag, DMA request and pin action show up at the same edge where the counter takes the match value.
- Bus writes act at the edge where they are presented, and reads can be observed within the same cycle.
- A capture load, or a counter-mode step, lands three edges after the capture input changes.

The bench keeps its own cycle model of these delays. Inputs are driven just after each rising edge. Read data, pins, DMA requests and the interrupt are compared with the model at every falling edge. As a result, a result that comes one cycle early or one cycle late shows up as a mismatch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int NUM_MATCH = 4;
  parameter int NUM_CAP   = 2;
  localparam int FLAG_W = NUM_MATCH + NUM_CAP;
  localparam int SEL_W  = (NUM_CAP > 1) ? $clog2(NUM_CAP) : 1;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_FLAG   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_SRC    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CAPCFG = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_IRQEN  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_PIN    = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_MATCH0 = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_CAPT0  = 4'd12;

  // edge selection code, shared by capture and counter mode (0 = off / internal clock)
  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_FALL = 2'd2;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  typedef enum logic [1:0] {PIN_KEEP = 2'd0, PIN_LOW = 2'd1, PIN_HIGH = 2'd2, PIN_FLIP = 2'd3} pinActT;

  typedef struct packed {
    logic                      run;
    logic                      hold;
    logic [1:0]                srcMode;
    logic [SEL_W-1:0]          srcSel;
    logic [NUM_CAP-1:0][1:0]   capEdge;
  } tmrCfgT;

  typedef struct packed {
    logic [NUM_CAP-1:0]   capHit;
    logic [NUM_MATCH-1:0] matchHit;
  } tmrEvtT;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  tmrCfgT                           cfg,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]  matchVal,
  input  logic [NUM_CAP-1:0]               capIn,
  output tmrEvtT                           evt,
  output logic [CNT_W-1:0]                 count,
  output logic [NUM_CAP-1:0][CNT_W-1:0]    capVal
);

  logic [NUM_CAP-1:0] syncA, syncB, syncC;
  logic [NUM_CAP-1:0] riseEv, fallEv, capEv;
  logic               srcEdge, tick;
  logic [CNT_W-1:0]   cntNext;

  function automatic logic edgePick(input logic [1:0] sel, input logic r, input logic f);
    case (sel)
      EDGE_RISE: edgePick = r;
      EDGE_FALL: edgePick = f;
      EDGE_BOTH: edgePick = r | f;
      default:   edgePick = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= capIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign riseEv = syncB & ~syncC;
  assign fallEv = ~syncB & syncC;

  generate
    for (genvar i = 0; i < NUM_CAP; i++) begin : gCap
      assign capEv[i] = edgePick(cfg.capEdge[i], riseEv[i], fallEv[i]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         capVal[i] <= '0;
        else if (capEv[i]) capVal[i] <= count;
      end

      AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
        capEv[i] |=> capVal[i] == $past(count)); // R7
    end
  endgenerate

  assign srcEdge = edgePick(cfg.srcMode, riseEv[cfg.srcSel], fallEv[cfg.srcSel]);
  assign tick    = cfg.run && !cfg.hold && ((cfg.srcMode == 2'd0) || srcEdge);
  assign cntNext = count + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (cfg.hold) count <= '0;
    else if (tick)     count <= cntNext;
  end

  generate
    for (genvar k = 0; k < NUM_MATCH; k++) begin : gMatch
      assign evt.matchHit[k] = tick && (cntNext == matchVal[k]);
    end
  endgenerate
  assign evt.capHit = capEv;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cfg.hold |=> count == '0); // R9
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !cfg.hold) |=> $stable(count)); // R9
  AST_NO_HIT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cfg.hold |-> evt.matchHit == '0); // R9

endmodule

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busSel,
  input  logic                             busWr,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [CNT_W-1:0]                 busWdata,
  output logic [CNT_W-1:0]                 busRdata,
  input  tmrEvtT                           evt,
  input  logic [CNT_W-1:0]                 count,
  input  logic [NUM_CAP-1:0][CNT_W-1:0]    capVal,
  output tmrCfgT                           cfg,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]  matchVal,
  output logic [NUM_MATCH-1:0]             matchOut,
  output logic [NUM_MATCH-1:0]             dmaReq,
  output logic                             irq
);

  localparam int SRC_W = 2 + SEL_W;
  localparam int ACT_W = 2 * NUM_MATCH;

  logic                 wrEn, wrFlag, wrPin;
  logic                 runBit, holdBit;
  logic [SRC_W-1:0]     srcReg;
  logic [2*NUM_CAP-1:0] capCfg;
  logic [NUM_MATCH-1:0] irqEn;
  logic [ACT_W-1:0]     pinAct;
  logic [FLAG_W-1:0]    flags, setVec, clrVec;

  assign wrEn   = busSel && busWr;
  assign wrFlag = wrEn && (busAddr == ADR_FLAG);
  assign wrPin  = wrEn && (busAddr == ADR_PIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      holdBit <= 1'b0;
      srcReg  <= '0;
      capCfg  <= '0;
      irqEn   <= '0;
      pinAct  <= '0;
    end else if (wrEn) begin
      case (busAddr)
        ADR_CTRL:   {holdBit, runBit} <= busWdata[1:0];
        ADR_SRC:    srcReg <= busWdata[SRC_W-1:0];
        ADR_CAPCFG: capCfg <= busWdata[2*NUM_CAP-1:0];
        ADR_IRQEN:  irqEn  <= busWdata[NUM_MATCH-1:0];
        ADR_PIN:    pinAct <= busWdata[NUM_MATCH +: ACT_W];
        default: ;
      endcase
    end
  end

  generate
    for (genvar k = 0; k < NUM_MATCH; k++) begin : gMreg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) matchVal[k] <= '0;
        else if (wrEn && busAddr == ADR_MATCH0 + ADDR_W'(k)) matchVal[k] <= busWdata;
      end

      logic pinBase;
      assign pinBase = wrPin ? busWdata[k] : matchOut[k];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) matchOut[k] <= 1'b0;
        else if (evt.matchHit[k]) begin
          case (pinActT'(pinAct[2*k +: 2]))
            PIN_LOW:  matchOut[k] <= 1'b0;
            PIN_HIGH: matchOut[k] <= 1'b1;
            PIN_FLIP: matchOut[k] <= ~pinBase;
            default:  matchOut[k] <= pinBase;
          endcase
        end else begin
          matchOut[k] <= pinBase;
        end
      end
    end
  endgenerate

  assign cfg.run     = runBit;
  assign cfg.hold    = holdBit;
  assign cfg.srcMode = srcReg[1:0];
  assign cfg.srcSel  = srcReg[SRC_W-1:2];
  assign cfg.capEdge = capCfg;

  assign setVec = {evt.capHit, evt.matchHit & irqEn};
  assign clrVec = wrFlag ? busWdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      dmaReq <= '0;
    end else begin
      flags  <= (flags & ~clrVec) | setVec;
      dmaReq <= (dmaReq & ~clrVec[NUM_MATCH-1:0]) | evt.matchHit;
    end
  end

  assign irq = |flags;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADR_FLAG:   busRdata[FLAG_W-1:0] = flags;
      ADR_CTRL:   busRdata[1:0] = {holdBit, runBit};
      ADR_SRC:    busRdata[SRC_W-1:0] = srcReg;
      ADR_CAPCFG: busRdata[2*NUM_CAP-1:0] = capCfg;
      ADR_IRQEN:  busRdata[NUM_MATCH-1:0] = irqEn;
      ADR_PIN:    busRdata[NUM_MATCH+ACT_W-1:0] = {pinAct, matchOut};
      ADR_COUNT:  busRdata = count;
      default: ;
    endcase
    for (int k = 0; k < NUM_MATCH; k++)
      if (busAddr == ADR_MATCH0 + ADDR_W'(k)) busRdata = matchVal[k];
    for (int i = 0; i < NUM_CAP; i++)
      if (busAddr == ADR_CAPT0 + ADDR_W'(i)) busRdata = capVal[i];
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setVec[0] |=> flags[0]); // R4
  AST_W1C_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlag && busWdata[NUM_MATCH] && !evt.capHit[0]) |=> !flags[NUM_MATCH]); // R3
  AST_DMA_RISE: assert property (@(posedge clk) disable iff (!rstN)
    evt.matchHit[0] |=> dmaReq[0]); // R5
  AST_DMA_WITHDRAW: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlag && busWdata[0] && !evt.matchHit[0]) |=> !dmaReq[0]); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADR_FLAG) |-> busRdata[CNT_W-1:FLAG_W] == '0); // R2
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rstN)
    irq == (flags != '0)); // R11

endmodule

// File: rtl/tmrCapMatch.sv
module tmrCapMatch
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CNT_W-1:0]     busWdata,
  output logic [CNT_W-1:0]     busRdata,
  input  logic [NUM_CAP-1:0]   capIn,
  output logic [NUM_MATCH-1:0] matchOut,
  output logic [NUM_MATCH-1:0] dmaReq,
  output logic                 irq
);

  tmrCfgT                          cfg;
  tmrEvtT                          evt;
  logic [CNT_W-1:0]                count;
  logic [NUM_CAP-1:0][CNT_W-1:0]   capVal;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVal;

  tmrCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evt(evt), .count(count),
    .capVal(capVal), .cfg(cfg), .matchVal(matchVal), .matchOut(matchOut),
    .dmaReq(dmaReq), .irq(irq)
  );

  tmrDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .matchVal(matchVal), .capIn(capIn),
    .evt(evt), .count(count), .capVal(capVal)
  );

endmodule

// File: tb/sim_tmrCapMatch.sv
module sim_tmrCapMatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  capIn = '0;
  logic [3:0]  matchOut, dmaReq;
  logic        irq;

  int nChecks = 0, nFails = 0;
  string phase = "R1";
  logic [3:0] rdAddr = '0;
  bit done = 0;

  tmrCapMatch u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .capIn(capIn), .matchOut(matchOut),
    .dmaReq(dmaReq), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [31:0] mCnt, mMatch[4], mCap[2];
  logic [5:0]  mFlags;
  logic [3:0]  mDma, mPins, mIrqEn, mCapCfg;
  logic [7:0]  mAct;
  logic [1:0]  mCtrl, ms1, ms2, ms3;
  logic [2:0]  mSrc;

  function automatic logic edgeFn(input logic [1:0] s, input logic r, input logic f);
    return (s == 2'd1) ? r : (s == 2'd2) ? f : (s == 2'd3) ? (r | f) : 1'b0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      4'd0: return {26'd0, mFlags};
      4'd1: return {30'd0, mCtrl};
      4'd2: return {29'd0, mSrc};
      4'd3: return {28'd0, mCapCfg};
      4'd4: return {28'd0, mIrqEn};
      4'd5: return {20'd0, mAct, mPins};
      4'd6: return mCnt;
      4'd8, 4'd9, 4'd10, 4'd11: return mMatch[a - 4'd8];
      4'd12, 4'd13: return mCap[a - 4'd12];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [1:0] r, f, capEv;
    logic tick, wr;
    logic [31:0] nxt;
    logic [3:0] hit, pb;
    logic [5:0] clr;
    if (!rstN) begin
      mCnt = 0; mCap[0] = 0; mCap[1] = 0; mFlags = 0; mDma = 0; mPins = 0;
      mIrqEn = 0; mCapCfg = 0; mAct = 0; mCtrl = 0; mSrc = 0;
      ms1 = 0; ms2 = 0; ms3 = 0;
      for (int k = 0; k < 4; k++) mMatch[k] = 0;
    end else begin
      wr = busSel && busWr;
      r = ms2 & ~ms3;
      f = ~ms2 & ms3;
      for (int i = 0; i < 2; i++) capEv[i] = edgeFn(mCapCfg[2*i +: 2], r[i], f[i]);
      tick = mCtrl[0] && !mCtrl[1] &&
             ((mSrc[1:0] == 2'd0) || edgeFn(mSrc[1:0], r[mSrc[2]], f[mSrc[2]]));
      nxt = mCnt + 1;
      for (int k = 0; k < 4; k++) hit[k] = tick && (nxt == mMatch[k]);
      pb = (wr && busAddr == 4'd5) ? busWdata[3:0] : mPins;
      for (int k = 0; k < 4; k++)
        if (hit[k])
          case (mAct[2*k +: 2])
            2'd1: pb[k] = 1'b0;
            2'd2: pb[k] = 1'b1;
            2'd3: pb[k] = ~pb[k];
            default: ;
          endcase
      mPins = pb;
      clr = (wr && busAddr == 4'd0) ? busWdata[5:0] : 6'd0;
      mFlags = (mFlags & ~clr) | {capEv, hit & mIrqEn};
      mDma = (mDma & ~clr[3:0]) | hit;
      for (int i = 0; i < 2; i++) if (capEv[i]) mCap[i] = mCnt;
      if (mCtrl[1]) mCnt = 0;
      else if (tick) mCnt = nxt;
      if (wr) begin
        case (busAddr)
          4'd1: mCtrl = busWdata[1:0];
          4'd2: mSrc = busWdata[2:0];
          4'd3: mCapCfg = busWdata[3:0];
          4'd4: mIrqEn = busWdata[3:0];
          4'd5: mAct = busWdata[11:4];
          4'd8, 4'd9, 4'd10, 4'd11: mMatch[busAddr - 4'd8] = busWdata;
          default: ;
        endcase
      end
      ms3 = ms2; ms2 = ms1; ms1 = capIn;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(busRdata == modelRead(busAddr), {phase, " rdata"}, busRdata, modelRead(busAddr));
      check(dmaReq == mDma, "R6 dmaReq", {28'd0, dmaReq}, {28'd0, mDma});
      check(matchOut == mPins, "R10 matchOut", {28'd0, matchOut}, {28'd0, mPins});
      check(irq == (mFlags != 0), "R11 irq", {31'd0, irq}, {31'd0, mFlags != 0});
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      busSel = 0; busWr = 0; busAddr = rdAddr;
      rdAddr = (rdAddr == 4'd13) ? 4'd0 : rdAddr + 1'b1;
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWr = 0;
  endtask

  task automatic toggleCap(input int ch, input int times, input int gap);
    for (int t = 0; t < times; t++) begin
      capIn[ch] = ~capIn[ch];
      cyc(gap);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1: explicit reset readback of every address
    for (int a = 0; a < 16; a++) begin
      busAddr = 4'(a);
      #1 check(busRdata == 32'd0, "R1 reset read", busRdata, 32'd0);
    end
    check(dmaReq == 0 && matchOut == 0 && irq == 0, "R1 outputs", {23'd0, dmaReq, matchOut, irq}, 32'd0);
    cyc(2);

    phase = "R5";
    wr(4'd8, 32'd5); wr(4'd9, 32'd8); wr(4'd10, 32'd3); wr(4'd11, 32'd20);
    wr(4'd4, 32'h7);
    wr(4'd5, {20'd0, 8'b11_01_11_10, 4'b0100}); // R10 actions: ch0 high, ch1 flip, ch2 low, ch3 flip
    wr(4'd1, 32'd1);
    cyc(30);

    phase = "R2";
    cyc(14);
    phase = "R3";
    wr(4'd0, 32'h0); cyc(2);
    wr(4'd0, 32'h1); cyc(2);
    phase = "R6";
    wr(4'd0, 32'h2); cyc(2);
    wr(4'd0, 32'hC); cyc(2);

    phase = "R9";
    wr(4'd1, 32'd3); cyc(3);
    wr(4'd1, 32'd0); cyc(5);
    phase = "R4";
    wr(4'd1, 32'd1);
    for (int i = 0; i < 12; i++) wr(4'd0, 32'h3F);
    cyc(4);

    phase = "R7";
    wr(4'd3, 32'b11_01);
    toggleCap(0, 6, 4);
    toggleCap(1, 6, 3);
    wr(4'd0, 32'h30);
    wr(4'd3, 32'b01_10);
    toggleCap(0, 4, 5);
    toggleCap(1, 4, 5);

    phase = "R8";
    wr(4'd1, 32'd3); wr(4'd1, 32'd1);
    wr(4'd2, 32'd1);
    toggleCap(0, 20, 3);
    wr(4'd2, 32'd7);
    toggleCap(1, 16, 2);
    wr(4'd2, 32'd6);
    toggleCap(1, 10, 4);
    toggleCap(0, 6, 3);

    phase = "R9";
    wr(4'd2, 32'd0);
    wr(4'd1, 32'd0);
    cyc(20);
    wr(4'd1, 32'd3); cyc(6);
    wr(4'd0, 32'h3F); cyc(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule